// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block chooses which of sixteen circular descriptor rings sends next and onto which of eight DMA channels that descriptor goes. Each ring is tied to one channel by its configuration word, and one channel may serve several rings. Each cycle the scheduler grants at most one descriptor. It names the channel, the ring and the ring slot on registered outputs. The DMA engine returns a completion pulse for a ring, and the ring's read index then moves forward by one.

Software programs the block through a word-addressed register port. The channel-enable mask, the ring-empty flags and the interrupt mask are global registers. Each ring also has a configuration word, a write index and a read index. A ring runs in one of two modes. In FIFO mode it keeps at most one descriptor outstanding. In window mode it may keep up to `WIN_SIZE` descriptors outstanding, provided its space-left flag is set. Each ring has a small state machine with three states: `QS_OFF` (inactive), `QS_RUN` (may be granted) and `QS_WAIT` (a FIFO-mode descriptor is outstanding). The transitions are as follows:
- `OFF->RUN`: the active bit is set.
- `RUN->WAIT`: a grant arrives in FIFO mode.
- `WAIT->RUN`: a completion arrives, or the host writes the read index.
- `RUN/WAIT->OFF`: the active bit is cleared.

Register map (word address, `QW` = log2 of the ring count). These are the field positions software relies on:
- `0x00`: channel enable. Bit c gates channel c.
- `0x01`: empty flags. Bits 15:0 hold the flags and bits 31:16 are their write enables.
- `0x02`: interrupt mask.
- `0x10+q`: configuration of ring q. Bit 0 is active. Bits 4:1 select the channel, and only the low log2(channels) bits are used. Bit 5 is space-left. Bit 8 selects window mode (1) or FIFO mode (0). Bits 19:10 are the write enables for bits 9:0.
- `0x20+q`: write index of ring q.
- `0x30+q`: read index of ring q.

Top module: `txq_sched_top`

## Requirements
- R1: After reset, all configuration words, write indices, read indices, the channel-enable mask and the interrupt mask read as zero. The empty register reads 0xFFFF. No grant and no interrupt are driven.
- R2: A configuration write changes bit i (i = 0..9) only when write-data bit 10+i is 1. Bits whose enable is 0 keep their value.
- R3: A ring is granted only when it is active and its empty flag is clear, and only on a channel whose enable bit is set. Setting the enable bit later lets the waiting ring through.
- R4: Writing a write index that differs from the read index clears that ring's empty flag. A completion that brings the read index up to the write index sets the flag.
- R5: A write to the empty register changes flag q only when bit 16+q is 1. While a flag is set, its ring receives no grant even if its indices differ.
- R6: A FIFO-mode ring receives a grant whose slot equals its read index. After that grant it receives no further grant until a completion arrives.
- R7: A window-mode ring with its space-left bit set receives grants for consecutive slots until `WIN_SIZE` descriptors are outstanding, and again once a completion frees room. When the space-left bit is cleared, the ring receives no further grants.
- R8: A completion for a ring with a descriptor outstanding advances its read index by one, wrapping from 255 to 0. A completion for a ring with nothing outstanding leaves the read index unchanged.
- R9: Rings bound to the same channel are granted in round-robin order of ring number, starting after the last ring granted on that channel.
- R10: When several enabled and ready channels have an eligible ring, the highest-numbered channel is granted.
- R11: One cycle after a completion is accepted for ring q, interrupt bit q pulses for exactly one cycle if mask bit q is set. A masked ring raises no interrupt.
- R12: At most one grant is issued per cycle. The grant appears on the outputs one clock after the decision, with the channel given one-hot. A channel whose ready input is low is passed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | QW+2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ch_ready_i | input | NUM_CH | Channel can accept a descriptor this cycle |
| cpl_valid_i | input | 1 | Completion pulse |
| cpl_q_i | input | QW | Ring the completion belongs to |
| gnt_ch_o | output | NUM_CH | One-hot channel of the grant, zero when idle |
| gnt_q_o | output | QW | Granted ring |
| gnt_idx_o | output | IDX_W | Granted ring slot |
| irq_o | output | NUM_Q | Per-ring read-advance interrupt pulses |

## Verification
The bench keeps sixteen rings, eight channels and 8-bit indices. It lowers `WIN_SIZE` to 4, so a window-mode ring fills its window within a few cycles. This brings the window-full stall and the reopening after a completion within reach of short directed tests. Because the indices stay 8 bits wide, the read index can be placed at 255 to exercise the wrap to 0.

// File: rtl/txq_pkg.sv
package txq_pkg;

    // per-ring state
    typedef enum logic [1:0] {
        QS_OFF  = 2'd0,
        QS_RUN  = 2'd1,
        QS_WAIT = 2'd2
    } qstate_e;

    // configuration word layout
    localparam int CFG_W      = 10;
    localparam int CFG_ACT    = 0;
    localparam int CFG_CH_LO  = 1;
    localparam int CFG_SPACE  = 5;
    localparam int CFG_WIN    = 8;
    localparam int CFG_EN_LO  = 10;

    // register regions (upper two address bits)
    localparam logic [1:0] RGN_GLOBAL = 2'd0;
    localparam logic [1:0] RGN_CFG    = 2'd1;
    localparam logic [1:0] RGN_WR     = 2'd2;
    localparam logic [1:0] RGN_RD     = 2'd3;

    // global register offsets inside RGN_GLOBAL
    localparam int GREG_CHEN  = 0;
    localparam int GREG_EMPTY = 1;
    localparam int GREG_IMASK = 2;

    // empty register write-enable field position
    localparam int EMPTY_EN_LO = 16;

endpackage

// File: rtl/txq_queue.sv
module txq_queue
    import txq_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int CH_W     = 3,
    parameter int WIN_SIZE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_val,
    input  logic [CFG_W-1:0] cfg_wen,
    input  logic             wr_we,
    input  logic             rd_we,
    input  logic [IDX_W-1:0] ptr_wdata,
    input  logic             empty_we,
    input  logic             empty_wval,
    input  logic             grant_i,
    input  logic             cpl_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [IDX_W-1:0] wr_o,
    output logic [IDX_W-1:0] rd_o,
    output logic [IDX_W-1:0] nxt_o,
    output logic [CH_W-1:0]  ch_o,
    output logic             empty_o,
    output logic             elig_o,
    output logic             adv_o
);

    localparam int CNT_W = IDX_W + 1;

    qstate_e          state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic [IDX_W-1:0] wr_q, rd_q, nxt_q;
    logic [IDX_W-1:0] in_flight;
    logic [IDX_W-1:0] rd_inc;
    logic             empty_q;
    logic             active, win_mode, space_ok, pending, room, cpl_ok;

    assign active    = cfg_q[CFG_ACT];
    assign win_mode  = cfg_q[CFG_WIN];
    assign space_ok  = cfg_q[CFG_SPACE];
    assign in_flight = nxt_q - rd_q;
    assign rd_inc    = rd_q + 1'b1;
    assign pending   = (nxt_q != wr_q);
    assign room      = ({1'b0, in_flight} < CNT_W'(WIN_SIZE));
    assign cpl_ok    = cpl_i && (nxt_q != rd_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QS_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_OFF:  if (active) state_d = QS_RUN;
            QS_RUN: begin
                if (!active)                    state_d = QS_OFF;
                else if (grant_i && !win_mode)  state_d = QS_WAIT;
            end
            QS_WAIT: begin
                if (!active)              state_d = QS_OFF;
                else if (cpl_ok || rd_we) state_d = QS_RUN;
            end
            default: state_d = QS_OFF;
        endcase
    end

    // outputs from state
    always_comb begin
        elig_o = 1'b0;
        unique case (state_q)
            QS_RUN: begin
                if (win_mode) elig_o = space_ok && pending && !empty_q && room;
                else          elig_o = pending && !empty_q;
            end
            QS_OFF, QS_WAIT: elig_o = 1'b0;
            default:         elig_o = 1'b0;
        endcase
    end

    // configuration with per-bit write enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= (cfg_q & ~cfg_wen) | (cfg_val & cfg_wen);
    end

    // indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            nxt_q <= '0;
        end else begin
            if (wr_we) wr_q <= ptr_wdata;
            if (rd_we) begin
                rd_q  <= ptr_wdata;
                nxt_q <= ptr_wdata;
            end else begin
                if (cpl_ok)  rd_q  <= rd_inc;
                if (grant_i) nxt_q <= nxt_q + 1'b1;
            end
        end
    end

    // empty flag: host override first, then index events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        empty_q <= 1'b1;
        else if (empty_we) empty_q <= empty_wval;
        else if (wr_we)    empty_q <= (ptr_wdata == rd_q);
        else if (rd_we)    empty_q <= (ptr_wdata == wr_q);
        else if (cpl_ok)   empty_q <= (rd_inc == wr_q);
    end

    assign cfg_o   = cfg_q;
    assign wr_o    = wr_q;
    assign rd_o    = rd_q;
    assign nxt_o   = nxt_q;
    assign ch_o    = cfg_q[CFG_CH_LO +: CH_W];
    assign empty_o = empty_q;
    assign adv_o   = cpl_ok;

    // R7
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_flight) <= WIN_SIZE);

    // R8
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_ok && !rd_we) |=> (rd_q == IDX_W'($past(rd_q) + 1'b1)));

    // R6
    fifo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !win_mode) |=> !grant_i);

endmodule

// File: rtl/txq_arb.sv
module txq_arb #(
    parameter int NUM_Q  = 16,
    parameter int NUM_CH = 8,
    parameter int QW     = $clog2(NUM_Q),
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  elig_i,
    input  logic [CH_W-1:0]   ch_of_i [NUM_Q],
    input  logic [NUM_CH-1:0] chen_i,
    input  logic [NUM_CH-1:0] ready_i,
    output logic              sel_valid_o,
    output logic [CH_W-1:0]   sel_ch_o,
    output logic [QW-1:0]     sel_q_o,
    output logic [NUM_Q-1:0]  gnt_vec_o
);

    logic [NUM_CH-1:0] ch_found;
    logic [QW-1:0]     ch_pick [NUM_CH];
    logic [NUM_CH-1:0] ch_live;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [QW-1:0] last_q;
        logic          found;
        logic [QW-1:0] pick;

        // round-robin search starting after the last granted ring
        always_comb begin
            found = 1'b0;
            pick  = '0;
            for (int k = 1; k <= NUM_Q; k++) begin
                if (!found && elig_i[(int'(last_q) + k) % NUM_Q] &&
                    ch_of_i[(int'(last_q) + k) % NUM_Q] == CH_W'(c)) begin
                    found = 1'b1;
                    pick  = QW'((int'(last_q) + k) % NUM_Q);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                last_q <= QW'(NUM_Q - 1);
            else if (sel_valid_o && sel_ch_o == CH_W'(c))
                last_q <= sel_q_o;
        end

        assign ch_found[c] = found;
        assign ch_pick[c]  = pick;
    end

    assign ch_live = ch_found & chen_i & ready_i;

    // fixed priority across channels: highest number wins
    always_comb begin
        sel_valid_o = 1'b0;
        sel_ch_o    = '0;
        sel_q_o     = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_live[c]) begin
                sel_valid_o = 1'b1;
                sel_ch_o    = CH_W'(c);
                sel_q_o     = ch_pick[c];
            end
        end
    end

    always_comb begin
        gnt_vec_o = '0;
        if (sel_valid_o) gnt_vec_o[sel_q_o] = 1'b1;
    end

    // R10
    prio_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> ((ch_live >> sel_ch_o) >> 1) == '0);

    // R3
    sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (elig_i[sel_q_o] && ch_of_i[sel_q_o] == sel_ch_o));

endmodule

// File: rtl/txq_sched_top.sv
module txq_sched_top
    import txq_pkg::*;
#(
    parameter int NUM_Q    = 16,
    parameter int NUM_CH   = 8,
    parameter int IDX_W    = 8,
    parameter int WIN_SIZE = 64,
    parameter int QW       = $clog2(NUM_Q),
    parameter int AW       = QW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ch_ready_i,
    input  logic              cpl_valid_i,
    input  logic [QW-1:0]     cpl_q_i,
    output logic [NUM_CH-1:0] gnt_ch_o,
    output logic [QW-1:0]     gnt_q_o,
    output logic [IDX_W-1:0]  gnt_idx_o,
    output logic [NUM_Q-1:0]  irq_o
);

    localparam int CH_W = $clog2(NUM_CH);

    logic [1:0]        rgn;
    logic [QW-1:0]     slot;
    logic [NUM_CH-1:0] chen_q;
    logic [NUM_Q-1:0]  imask_q;
    logic              chen_we, imask_we, empty_we;

    logic [CFG_W-1:0]  q_cfg  [NUM_Q];
    logic [IDX_W-1:0]  q_wr   [NUM_Q];
    logic [IDX_W-1:0]  q_rd   [NUM_Q];
    logic [IDX_W-1:0]  q_nxt  [NUM_Q];
    logic [CH_W-1:0]   q_ch   [NUM_Q];
    logic [NUM_Q-1:0]  q_empty, q_elig, q_adv;

    logic              sel_valid;
    logic [CH_W-1:0]   sel_ch;
    logic [QW-1:0]     sel_q;
    logic [NUM_Q-1:0]  gnt_vec;

    assign rgn      = reg_addr[AW-1 -: 2];
    assign slot     = reg_addr[QW-1:0];
    assign chen_we  = reg_we && rgn == RGN_GLOBAL && int'(slot) == GREG_CHEN;
    assign empty_we = reg_we && rgn == RGN_GLOBAL && int'(slot) == GREG_EMPTY;
    assign imask_we = reg_we && rgn == RGN_GLOBAL && int'(slot) == GREG_IMASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chen_q  <= '0;
            imask_q <= '0;
        end else begin
            if (chen_we)  chen_q  <= reg_wdata[NUM_CH-1:0];
            if (imask_we) imask_q <= reg_wdata[NUM_Q-1:0];
        end
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        txq_queue #(
            .IDX_W   (IDX_W),
            .CH_W    (CH_W),
            .WIN_SIZE(WIN_SIZE)
        ) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (reg_we && rgn == RGN_CFG && slot == QW'(q)),
            .cfg_val   (reg_wdata[CFG_W-1:0]),
            .cfg_wen   (reg_wdata[CFG_EN_LO +: CFG_W]),
            .wr_we     (reg_we && rgn == RGN_WR && slot == QW'(q)),
            .rd_we     (reg_we && rgn == RGN_RD && slot == QW'(q)),
            .ptr_wdata (reg_wdata[IDX_W-1:0]),
            .empty_we  (empty_we && reg_wdata[EMPTY_EN_LO + q]),
            .empty_wval(reg_wdata[q]),
            .grant_i   (gnt_vec[q]),
            .cpl_i     (cpl_valid_i && cpl_q_i == QW'(q)),
            .cfg_o     (q_cfg[q]),
            .wr_o      (q_wr[q]),
            .rd_o      (q_rd[q]),
            .nxt_o     (q_nxt[q]),
            .ch_o      (q_ch[q]),
            .empty_o   (q_empty[q]),
            .elig_o    (q_elig[q]),
            .adv_o     (q_adv[q])
        );
    end

    txq_arb #(
        .NUM_Q (NUM_Q),
        .NUM_CH(NUM_CH),
        .QW    (QW),
        .CH_W  (CH_W)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig_i     (q_elig),
        .ch_of_i    (q_ch),
        .chen_i     (chen_q),
        .ready_i    (ch_ready_i),
        .sel_valid_o(sel_valid),
        .sel_ch_o   (sel_ch),
        .sel_q_o    (sel_q),
        .gnt_vec_o  (gnt_vec)
    );

    // registered grant and interrupt outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_ch_o  <= '0;
            gnt_q_o   <= '0;
            gnt_idx_o <= '0;
            irq_o     <= '0;
        end else begin
            gnt_ch_o  <= sel_valid ? (NUM_CH'(1) << sel_ch) : '0;
            gnt_q_o   <= sel_q;
            gnt_idx_o <= q_nxt[sel_q];
            irq_o     <= q_adv & imask_q;
        end
    end

    // register read-back
    always_comb begin
        reg_rdata = '0;
        unique case (rgn)
            RGN_GLOBAL: begin
                if (int'(slot) == GREG_CHEN)  reg_rdata[NUM_CH-1:0] = chen_q;
                if (int'(slot) == GREG_EMPTY) reg_rdata[NUM_Q-1:0]  = q_empty;
                if (int'(slot) == GREG_IMASK) reg_rdata[NUM_Q-1:0]  = imask_q;
            end
            RGN_CFG: reg_rdata[CFG_W-1:0] = q_cfg[slot];
            RGN_WR:  reg_rdata[IDX_W-1:0] = q_wr[slot];
            RGN_RD:  reg_rdata[IDX_W-1:0] = q_rd[slot];
            default: reg_rdata = '0;
        endcase
    end

    // R12
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_ch_o));

    // R3
    gnt_chen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_ch_o) |-> ((gnt_ch_o & $past(chen_q)) != '0));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~$past(imask_q)) == '0);

endmodule

// File: tb/txq_sched_top_bench.sv
module txq_sched_top_bench;

    localparam int NQ = 16;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] ch_ready = '0;
    logic          cpl_valid = 1'b0;
    logic [3:0]    cpl_q = '0;
    logic [NC-1:0] gnt_ch;
    logic [3:0]    gnt_q;
    logic [7:0]    gnt_idx;
    logic [NQ-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    txq_sched_top #(.NUM_Q(NQ), .NUM_CH(NC), .IDX_W(8), .WIN_SIZE(4)) u_txq_sched_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_ready_i(ch_ready),
        .cpl_valid_i(cpl_valid), .cpl_q_i(cpl_q), .gnt_ch_o(gnt_ch),
        .gnt_q_o(gnt_q), .gnt_idx_o(gnt_idx), .irq_o(irq)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; reg_we = 1'b0; ch_ready = '0; cpl_valid = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wreg(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cpl(input logic [3:0] q);
        cpl_valid = 1'b1; cpl_q = q;
        tick();
        cpl_valid = 1'b0;
    endtask

    // full-enable configuration write
    function automatic logic [31:0] cfgw(input logic [9:0] v);
        return 32'h000F_FC00 | {22'd0, v};
    endfunction

    function automatic logic [5:0] a_cfg(input int q); return 6'(16 + q); endfunction
    function automatic logic [5:0] a_wr (input int q); return 6'(32 + q); endfunction
    function automatic logic [5:0] a_rd (input int q); return 6'(48 + q); endfunction

    task automatic expect_gnt(input string tag, input logic [7:0] ch, input int q, input int idx);
        chk({tag, " grant channel"}, 32'(gnt_ch), 32'(ch));
        if (ch != 0) begin
            chk({tag, " grant ring"}, 32'(gnt_q), 32'(q));
            chk({tag, " grant slot"}, 32'(gnt_idx), 32'(idx));
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_reset();
        rreg(a_cfg(3), d); chk("R1 cfg", d, 0);
        rreg(a_wr(7), d);  chk("R1 wr", d, 0);
        rreg(a_rd(7), d);  chk("R1 rd", d, 0);
        rreg(6'd1, d);     chk("R1 empty", d, 32'hFFFF);
        rreg(6'd0, d);     chk("R1 chen", d, 0);
        rreg(6'd2, d);     chk("R1 imask", d, 0);
        chk("R1 gnt", 32'(gnt_ch), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_cfg_mask;
        logic [31:0] d;
        do_reset();
        wreg(a_cfg(3), 32'h0000_7C00 | 32'h3FF);
        rreg(a_cfg(3), d); chk("R2 partial enable", d, 32'h01F);
        wreg(a_cfg(3), 32'h0000_0400);
        rreg(a_cfg(3), d); chk("R2 single bit clear", d, 32'h01E);
        wreg(a_cfg(3), 32'h0000_0000 | 32'h3FF);
        rreg(a_cfg(3), d); chk("R2 no enables", d, 32'h01E);
    endtask

    task automatic t_fifo;
        logic [31:0] d;
        do_reset();
        wreg(a_cfg(0), cfgw(10'h003));
        wreg(a_wr(0), 3);
        wreg(6'd0, 32'h02);
        rreg(6'd1, d); chk("R4 empty cleared", d & 32'h1, 0);
        ch_ready = '1;
        tick(); expect_gnt("R6 first", 8'h02, 0, 0);
        tick(); expect_gnt("R6 hold", 8'h00, 0, 0);
        tick(); expect_gnt("R6 hold2", 8'h00, 0, 0);
        cpl(0);
        rreg(a_rd(0), d); chk("R8 step", d, 1);
        tick(); expect_gnt("R6 second", 8'h02, 0, 1);
        cpl(0);
        tick(); expect_gnt("R6 third", 8'h02, 0, 2);
        cpl(0);
        rreg(6'd1, d); chk("R4 empty set", d & 32'h1, 1);
        tick(); expect_gnt("R4 drained", 8'h00, 0, 0);
    endtask

    task automatic t_window;
        do_reset();
        wreg(a_cfg(5), cfgw(10'h125));
        wreg(a_wr(5), 10);
        wreg(6'd0, 32'h04);
        ch_ready = 8'h04;
        for (int i = 0; i < 4; i++) begin
            tick(); expect_gnt("R7 burst", 8'h04, 5, i);
        end
        tick(); expect_gnt("R7 window full", 8'h00, 0, 0);
        cpl(5);
        tick(); expect_gnt("R7 reopened", 8'h04, 5, 4);
        wreg(a_cfg(5), 32'h0000_8000);
        cpl(5);
        tick(); expect_gnt("R7 space-left clear", 8'h00, 0, 0);
    endtask

    task automatic t_rr;
        do_reset();
        for (int q = 1; q <= 3; q++) begin
            wreg(a_cfg(q), cfgw(10'h121));
            wreg(a_wr(q), 10);
        end
        wreg(6'd0, 32'h01);
        ch_ready = 8'h01;
        for (int i = 0; i < 6; i++) begin
            tick(); expect_gnt("R9 rotation", 8'h01, 1 + (i % 3), i / 3);
        end
    endtask

    task automatic t_prio;
        do_reset();
        wreg(a_cfg(6), cfgw(10'h127));
        wreg(a_cfg(7), cfgw(10'h12B));
        wreg(a_wr(6), 10);
        wreg(a_wr(7), 10);
        wreg(6'd0, 32'h28);
        ch_ready = 8'h08;
        tick(); expect_gnt("R12 ready gating", 8'h08, 6, 0);
        ch_ready = '1;
        for (int i = 0; i < 4; i++) begin
            tick(); expect_gnt("R10 high channel first", 8'h20, 7, i);
        end
        for (int i = 1; i < 4; i++) begin
            tick(); expect_gnt("R10 low channel after", 8'h08, 6, i);
        end
        tick(); expect_gnt("R12 idle", 8'h00, 0, 0);
    endtask

    task automatic t_chen;
        do_reset();
        wreg(a_cfg(8), cfgw(10'h009));
        wreg(a_wr(8), 2);
        wreg(6'd0, 32'hEF);
        ch_ready = '1;
        tick(); expect_gnt("R3 disabled channel", 8'h00, 0, 0);
        tick(); expect_gnt("R3 disabled channel 2", 8'h00, 0, 0);
        wreg(6'd0, 32'hFF);
        tick(); expect_gnt("R3 enabled channel", 8'h10, 8, 0);
    endtask

    task automatic t_empty;
        logic [31:0] d;
        do_reset();
        wreg(a_cfg(12), cfgw(10'h001));
        wreg(a_wr(12), 2);
        wreg(6'd0, 32'h01);
        wreg(6'd1, (32'h1 << 28) | (32'h1 << 19) | (32'h1 << 12));
        rreg(6'd1, d); chk("R5 masked empty write", d, 32'hFFF7);
        ch_ready = 8'h01;
        tick(); expect_gnt("R5 empty gates", 8'h00, 0, 0);
        tick(); expect_gnt("R5 empty gates 2", 8'h00, 0, 0);
        wreg(6'd1, 32'h1 << 28);
        tick(); expect_gnt("R5 released", 8'h01, 12, 0);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        do_reset();
        wreg(a_cfg(9), cfgw(10'h001));
        wreg(a_rd(9), 255);
        wreg(a_wr(9), 1);
        wreg(6'd0, 32'h01);
        ch_ready = 8'h01;
        tick(); expect_gnt("R8 slot 255", 8'h01, 9, 255);
        cpl(9);
        rreg(a_rd(9), d); chk("R8 wrap", d, 0);
        tick(); expect_gnt("R8 slot 0", 8'h01, 9, 0);
        cpl(9);
        rreg(6'd1, d); chk("R4 empty after wrap", (d >> 9) & 1, 1);
        cpl(9);
        rreg(a_rd(9), d); chk("R8 idle completion ignored", d, 1);
        cpl(10);
        rreg(a_rd(10), d); chk("R8 inactive completion ignored", d, 0);
    endtask

    task automatic t_irq;
        do_reset();
        wreg(a_cfg(0), cfgw(10'h001));
        wreg(a_wr(0), 1);
        wreg(6'd2, 32'h0001);
        wreg(6'd0, 32'h01);
        ch_ready = 8'h01;
        tick(); expect_gnt("R11 setup grant", 8'h01, 0, 0);
        cpl(0);
        chk("R11 pulse", 32'(irq), 32'h0001);
        tick();
        chk("R11 pulse ends", 32'(irq), 0);
        wreg(6'd2, 32'h0000);
        wreg(a_wr(0), 2);
        tick(); expect_gnt("R11 second grant", 8'h01, 0, 1);
        cpl(0);
        chk("R11 masked", 32'(irq), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_cfg_mask();
        t_fifo();
        t_window();
        t_rr();
        t_prio();
        t_chen();
        t_empty();
        t_wrap();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule